// File: doc/BRIEF.md
# Freezable Event Counter Monitor Box

This block is a performance-monitoring unit for one functional unit of a larger chip. It holds four programmable event counters. Each counter has its own control word that picks one of eight incoming event pulses, switches the counter on, and decides whether an overflow is reported. Software reaches every register through a simple port with address, write data, write strobe and combinational read data.

A counter that wraps while its overflow reporting is on does two things. It sets its own bit in the box status word, and it sends a one-cycle message to a small global collector that is also inside this block. On that message the collector latches a global overflow flag, drops the global counting enable, and, if interrupts are allowed, raises an interrupt request. All counting then stops and the counter values are held. Software clears both flag levels by writing ones to them and then sets the global enable again. Counting picks up from the held values.

Only the first report per box bit can freeze the counters. A box bit that is still set sends no further message, and a global flag that is still set ignores further messages.

Top module: `evmon_box`

## Requirements
- R1: After reset every readable register reads zero, and `ovf_msg_o` and `irq_o` are low.
- R2: Counter i adds one on each clock edge where its selected event input is high, bit 22 of its control word (offset 0xD8+4i) is 1, and global control bit 0 (offset 0x00) is 1. A select value in bits 7:0 of 8 or more never counts.
- R3: Each counter is 48 bits wide. The low word is at 0xA0+8i. The high word is at 0xA4+8i and carries bits 47:32 in its bits 15:0, with bits 31:16 reading zero. From all ones a counter wraps to zero and keeps counting.
- R4: A write to either counter half in the same cycle as a qualifying event loads the written value, and the event is lost.
- R5: A wrap of counter i whose control bit 20 is 1 sets bit i of box status (0xF8) on the wrap edge. If that bit was clear, `ovf_msg_o` is high for exactly the following cycle. A wrap with bit 20 at 0 sets nothing and sends nothing.
- R6: When the message arrives and global status bit 0 (0x04) is clear, global status bit 0 is set and global control bit 0 is cleared on the next edge. `irq_o` is high whenever global status bit 0 and global control bit 1 are both 1.
- R7: From the wrap edge until software sets the global enable again, no counter changes except by a software write. After re-enabling, counting resumes from the held values.
- R8: A set box status bit blocks any new message for that counter. A message that arrives while global status bit 0 is set neither clears the global enable nor changes global status.
- R9: Box status bits and global status bit 0 clear only when 1 is written to them. Writing 0 leaves them unchanged.
- R10: Writing 1 to bit 1 of box control (0xF4) zeroes all counters. Writing 1 to bit 0 zeroes all control words. Box control always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_i | input | 8 | Event pulse inputs |
| ovf_msg_o | output | 1 | One-cycle overflow message to the collector |
| irq_o | output | 1 | Interrupt request |

## Verification
A box status bit that fails to set would let a second wrap send a second message. The bench detects this on `ovf_msg_o` in the cycle after that wrap. A collector enable that stays high after the message would let counters keep moving, and the counter read-back shows this one cycle later. A flag that clears without a write of 1 shows up at once on `irq_o` and in the status read-back. A lost write priority shows up in the counter value read right after the colliding write.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam logic [7:0] OFS_GCTL  = 8'h00;
  localparam logic [7:0] OFS_GSTAT = 8'h04;
  localparam logic [7:0] OFS_BCTL  = 8'hF4;
  localparam logic [7:0] OFS_BSTAT = 8'hF8;
  localparam logic [7:0] OFS_CCTL0 = 8'hD8;
  localparam logic [7:0] OFS_CNT0  = 8'hA0;
  localparam int CTL_OVFEN = 20;
  localparam int CTL_EN    = 22;
  localparam int BCTL_CTLRST = 0;
  localparam int BCTL_CNTRST = 1;
endpackage

// File: rtl/evmon_ctr.sv
module evmon_ctr #(
  parameter int CTR_W   = 48,
  parameter int NUM_EVT = 8,
  parameter int SEL_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               lo_we,
  input  logic               hi_we,
  input  logic [31:0]        wdata,
  input  logic               ctl_rst,
  input  logic               cnt_rst,
  input  logic               run,
  input  logic [NUM_EVT-1:0] evt,
  output logic [31:0]        ctl_q,
  output logic [CTR_W-1:0]   cnt_q,
  output logic               ovf_o
);
  import evmon_pkg::*;
  localparam int IDX_W = $clog2(NUM_EVT);
  localparam int HI_W  = CTR_W - 32;

  function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic at_top(input logic [CTR_W-1:0] v);
    return &v;
  endfunction

  logic [SEL_W-1:0] sel;
  logic             sel_hit;
  logic             inc;

  assign sel     = ctl_q[SEL_W-1:0];
  assign sel_hit = (sel < SEL_W'(NUM_EVT)) ? evt[sel[IDX_W-1:0]] : 1'b0;
  assign inc     = sel_hit && ctl_q[CTL_EN] && run && !lo_we && !hi_we;
  assign ovf_o   = inc && at_top(cnt_q) && ctl_q[CTL_OVFEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (ctl_rst) ctl_q <= '0;
    else if (ctl_we)  ctl_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_rst)    cnt_q <= '0;
    else if (lo_we)      cnt_q[31:0] <= wdata;
    else if (hi_we)      cnt_q[CTR_W-1:32] <= wdata[HI_W-1:0];
    else if (inc)        cnt_q <= bump(cnt_q);
  end
endmodule

// File: rtl/evmon_gcol.sv
module evmon_gcol (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic        stat_we,
  input  logic [31:0] wdata,
  input  logic        msg,
  output logic        gen_q,
  output logic        irqen_q,
  output logic        gstat_q,
  output logic        irq_o
);
  logic freeze_evt;
  assign freeze_evt = msg && !gstat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= 1'b0;
      irqen_q <= 1'b0;
      gstat_q <= 1'b0;
    end else begin
      if (ctl_we) irqen_q <= wdata[1];
      if (freeze_evt)  gen_q <= 1'b0;
      else if (ctl_we) gen_q <= wdata[0];
      if (freeze_evt)                gstat_q <= 1'b1;
      else if (stat_we && wdata[0])  gstat_q <= 1'b0;
    end
  end

  assign irq_o = gstat_q && irqen_q;
endmodule

// File: rtl/evmon_box.sv
module evmon_box #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_we,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               ovf_msg_o,
  output logic               irq_o
);
  import evmon_pkg::*;
  localparam int HI_W = CTR_W - 32;

  logic [NUM_CTR-1:0]       ovf_vec;
  logic [NUM_CTR-1:0]       bstat_q;
  logic [NUM_CTR-1:0]       bstat_clr;
  logic [31:0]              ctl_arr [NUM_CTR];
  logic [CTR_W-1:0]         cnt_arr [NUM_CTR];
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;
  logic                     gen_q, irqen_q, gstat_q;
  logic                     run;
  logic                     bctl_we, ctl_rst, cnt_rst;
  logic                     msg_q;

  assign bctl_we = reg_we && (reg_addr == OFS_BCTL);
  assign ctl_rst = bctl_we && reg_wdata[BCTL_CTLRST];
  assign cnt_rst = bctl_we && reg_wdata[BCTL_CNTRST];
  assign run     = gen_q && !msg_q;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam logic [7:0] A_CTL = 8'(OFS_CCTL0 + 4*i);
    localparam logic [7:0] A_LO  = 8'(OFS_CNT0 + 8*i);
    localparam logic [7:0] A_HI  = 8'(OFS_CNT0 + 8*i + 4);
    evmon_ctr #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT), .SEL_W(8)) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_we  (reg_we && reg_addr == A_CTL),
      .lo_we   (reg_we && reg_addr == A_LO),
      .hi_we   (reg_we && reg_addr == A_HI),
      .wdata   (reg_wdata),
      .ctl_rst (ctl_rst),
      .cnt_rst (cnt_rst),
      .run     (run),
      .evt     (evt_i),
      .ctl_q   (ctl_arr[i]),
      .cnt_q   (cnt_arr[i]),
      .ovf_o   (ovf_vec[i])
    );
    assign cnt_flat[i*CTR_W +: CTR_W] = cnt_arr[i];
  end

  assign bstat_clr = (reg_we && reg_addr == OFS_BSTAT) ? reg_wdata[NUM_CTR-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bstat_q <= '0;
      msg_q   <= 1'b0;
    end else begin
      bstat_q <= (bstat_q & ~bstat_clr) | ovf_vec;
      msg_q   <= |(ovf_vec & ~bstat_q);
    end
  end
  assign ovf_msg_o = msg_q;

  evmon_gcol gcol_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_we  (reg_we && reg_addr == OFS_GCTL),
    .stat_we (reg_we && reg_addr == OFS_GSTAT),
    .wdata   (reg_wdata),
    .msg     (msg_q),
    .gen_q   (gen_q),
    .irqen_q (irqen_q),
    .gstat_q (gstat_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_GCTL)  reg_rdata = {30'b0, irqen_q, gen_q};
    if (reg_addr == OFS_GSTAT) reg_rdata = {31'b0, gstat_q};
    if (reg_addr == OFS_BSTAT) reg_rdata = 32'(bstat_q);
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == 8'(OFS_CCTL0 + 4*i)) reg_rdata = ctl_arr[i];
      if (reg_addr == 8'(OFS_CNT0 + 8*i))  reg_rdata = cnt_arr[i][31:0];
      if (reg_addr == 8'(OFS_CNT0 + 8*i + 4))
        reg_rdata = {{(32-HI_W){1'b0}}, cnt_arr[i][CTR_W-1:32]};
    end
  end
endmodule

// File: rtl/evmon_box_chk.sv
module evmon_box_chk #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_we,
  input logic [7:0]               reg_addr,
  input logic                     ovf_msg_o,
  input logic                     irq_o,
  input logic                     gen_q,
  input logic                     irqen_q,
  input logic                     gstat_q,
  input logic [NUM_CTR-1:0]       bstat_q,
  input logic [NUM_CTR-1:0]       ovf_vec,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);
  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_msg_o && !gstat_q |=> gstat_q && !gen_q);

  a_r6_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_msg_o && !gstat_q && irqen_q && !(reg_we && reg_addr == 8'h00) |=> irq_o);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_msg_o || !gen_q) && !reg_we |=> $stable(cnt_flat));

  a_r5_flag: assert property (@(posedge clk) disable iff (!rst_n)
    |ovf_vec |=> ((bstat_q & $past(ovf_vec)) == $past(ovf_vec)));

  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_msg_o |=> !ovf_msg_o);

  a_r8_no_msg: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_vec & ~bstat_q) == '0 |=> !ovf_msg_o);
endmodule

bind evmon_box evmon_box_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .ovf_msg_o (ovf_msg_o),
  .irq_o     (irq_o),
  .gen_q     (gen_q),
  .irqen_q   (irqen_q),
  .gstat_q   (gstat_q),
  .bstat_q   (bstat_q),
  .ovf_vec   (ovf_vec),
  .cnt_flat  (cnt_flat)
);

// File: tb/evmon_box_tb_top.sv
module evmon_box_tb_top;
  localparam logic [7:0] GCTL = 8'h00, GSTAT = 8'h04, BCTL = 8'hF4, BSTAT = 8'hF8;
  localparam logic [31:0] EN = 32'h0040_0000, OVE = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_i = '0;
  logic        ovf_msg_o, irq_o;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  evmon_box dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .ovf_msg_o(ovf_msg_o), .irq_o(irq_o));

  function automatic logic [7:0] a_ctl(input int i); return 8'(8'hD8 + 4*i); endfunction
  function automatic logic [7:0] a_lo(input int i);  return 8'(8'hA0 + 8*i); endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd_cnt(input int i, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a_lo(i), lo); rd(a_lo(i) + 8'd4, hi);
    v = {hi, lo};
  endtask

  task automatic pulse(input logic [7:0] e, input int n);
    evt_i = e;
    repeat (n) @(posedge clk);
    @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [63:0] v;
    rd(GCTL, d); chk("R1 gctl", d, 0);
    rd(GSTAT, d); chk("R1 gstat", d, 0);
    rd(BSTAT, d); chk("R1 bstat", d, 0);
    for (int i = 0; i < 4; i++) begin
      rd(a_ctl(i), d); chk("R1 ctl", d, 0);
      rd_cnt(i, v); chk("R1 cnt", v, 0);
    end
    chk("R1 msg/irq", {ovf_msg_o, irq_o}, 0);
  endtask

  task automatic t_count;
    logic [63:0] v; logic [31:0] d;
    wr(a_ctl(0), EN | 32'd2);
    wr(a_ctl(1), EN | 32'd9);
    wr(a_ctl(2), 32'd2);
    wr(GCTL, 32'd1);
    pulse(8'h04, 5);
    rd_cnt(0, v); chk("R2 count", v, 5);
    rd_cnt(1, v); chk("R2 bad select", v, 0);
    rd_cnt(2, v); chk("R2 local off", v, 0);
    wr(GCTL, 32'd0);
    pulse(8'h04, 3);
    rd_cnt(0, v); chk("R2 global off", v, 5);
    wr(a_lo(3), 32'hFFFF_FFFF);
    wr(a_lo(3) + 8'd4, 32'h1234_FFFF);
    rd(a_lo(3) + 8'd4, d); chk("R3 high word", d, 32'h0000_FFFF);
    wr(a_ctl(3), EN | 32'd1);
    wr(GCTL, 32'd1);
    evt_i = 8'h02; @(posedge clk); @(negedge clk); evt_i = '0;
    rd_cnt(3, v); chk("R3 wrap", v, 0);
    chk("R5 no msg w/o ovf enable", ovf_msg_o, 0);
    rd(BSTAT, d); chk("R5 no flag w/o ovf enable", d, 0);
  endtask

  task automatic t_wpri;
    logic [63:0] v;
    evt_i = 8'h04;
    wr(a_lo(0), 32'd100);
    evt_i = '0;
    rd_cnt(0, v); chk("R4 write wins", v, 100);
  endtask

  task automatic t_freeze;
    logic [63:0] v; logic [31:0] d;
    wr(BCTL, 32'h2);
    wr(a_ctl(0), EN | OVE);
    wr(a_ctl(1), EN);
    wr(a_ctl(2), 32'd0);
    wr(a_ctl(3), 32'd0);
    wr(a_lo(0), 32'hFFFF_FFFD);
    wr(a_lo(0) + 8'd4, 32'h0000_FFFF);
    wr(GCTL, 32'd3);
    evt_i = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 msg pulse", ovf_msg_o, 1);
    rd(BSTAT, d); chk("R5 box flag", d, 1);
    rd_cnt(0, v); chk("R3 wrap to zero", v, 0);
    chk("R6 irq not yet", irq_o, 0);
    @(negedge clk);
    chk("R5 msg one cycle", ovf_msg_o, 0);
    chk("R6 irq", irq_o, 1);
    rd(GSTAT, d); chk("R6 gstat set", d, 1);
    rd(GCTL, d); chk("R6 gen cleared", d, 2);
    repeat (3) @(negedge clk);
    evt_i = '0;
    rd_cnt(1, v); chk("R7 frozen", v, 3);
    rd_cnt(0, v); chk("R7 frozen wrapped", v, 0);
    // R8: global flag still set, so a second message does not freeze
    wr(a_ctl(2), EN | OVE);
    wr(a_lo(2), 32'hFFFF_FFFF);
    wr(a_lo(2) + 8'd4, 32'h0000_FFFF);
    wr(GCTL, 32'd3);
    evt_i = 8'h01; @(posedge clk); @(negedge clk); evt_i = '0;
    chk("R8 msg from clear bit", ovf_msg_o, 1);
    @(negedge clk);
    rd(GCTL, d); chk("R8 no refreeze", d, 3);
    rd(GSTAT, d); chk("R8 gstat held", d, 1);
    rd(BSTAT, d); chk("R8 bstat", d, 5);
    // R9: write-one-to-clear
    wr(BSTAT, 32'h0);
    rd(BSTAT, d); chk("R9 zero write", d, 5);
    wr(GSTAT, 32'h0);
    rd(GSTAT, d); chk("R9 zero write g", d, 1);
    wr(BSTAT, 32'h1);
    rd(BSTAT, d); chk("R9 clear bit0", d, 4);
    chk("R9 irq kept", irq_o, 1);
    wr(GSTAT, 32'h1);
    rd(GSTAT, d); chk("R9 gstat cleared", d, 0);
    chk("R9 irq dropped", irq_o, 0);
    wr(BSTAT, 32'h4);
    rd(BSTAT, d); chk("R9 clear bit2", d, 0);
    pulse(8'h01, 2);
    rd_cnt(0, v); chk("R7 resume c0", v, 3);
    rd_cnt(1, v); chk("R7 resume c1", v, 6);
    rd_cnt(2, v); chk("R7 resume c2", v, 2);
    // R8: both levels cleared, a new freeze occurs
    wr(a_lo(0), 32'hFFFF_FFFF);
    wr(a_lo(0) + 8'd4, 32'h0000_FFFF);
    evt_i = 8'h01; @(posedge clk); @(negedge clk); evt_i = '0;
    chk("R8 new msg", ovf_msg_o, 1);
    @(negedge clk);
    rd(GCTL, d); chk("R8 refreeze", d, 2);
    chk("R6 irq again", irq_o, 1);
  endtask

  task automatic t_boxctl;
    logic [63:0] v; logic [31:0] d;
    wr(BCTL, 32'h2);
    rd_cnt(1, v); chk("R10 counters cleared", v, 0);
    rd(a_ctl(1), d); chk("R10 ctl kept", d, EN);
    rd(BCTL, d); chk("R10 box ctl reads 0", d, 0);
    wr(BCTL, 32'h1);
    rd(a_ctl(0), d); chk("R10 ctl0 cleared", d, 0);
    rd(a_ctl(1), d); chk("R10 ctl1 cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_wpri();
    t_freeze();
    t_boxctl();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule